// File: doc/BRIEF.md
# Split-Accumulator Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a 32-bit processor core. It keeps a 64-bit accumulator as two 32-bit words, a high word and a low word, with an explicit carry from the low word into the high word. It also holds an auxiliary 32-bit product register, a registered result word and a sticky overflow flag. Each cycle in which `in_valid` is high, a 4-bit opcode picks one operation on the two 32-bit operands. The operations are a full 32x32 multiply-accumulate, a byte multiply-accumulate, a halfword multiply-accumulate, a dual-halfword multiply-accumulate and a dual-halfword multiply without accumulate. Each comes in a signed and an unsigned variant.

Every mode accumulates at its own width. The full and halfword modes update both accumulator words. The byte and dual-halfword accumulate modes update only the low word. The overflow flag follows a sign rule on the word that was written. Once the flag is set, it stays set until the `ovf_clr` input is pulsed. The dual multiply writes its two lane products to the auxiliary register and to the result output. It leaves the accumulator alone. All state is shown on outputs so that a later extraction or saturation stage can read it.

Top module: `mac_split_acc`

## Requirements
- R1: After reset, acc_hi, acc_lo, aux_q, res_q and ovf are all zero.
- R2: Opcodes 0 (signed) and 1 (unsigned) form the 64-bit product of opa and opb. They add its low 32 bits to acc_lo, then add its high 32 bits plus the carry out of that add to acc_hi, so that {acc_hi, acc_lo} grows by the full product modulo 2^64.
- R3: For opcodes 0, 1, 4 and 5, an overflow event occurs when bit 31 of the old acc_hi equals bit 63 of the product and bit 31 of the new acc_hi differs from it. An event sets ovf.
- R4: ovf is sticky. No operation clears it. It returns to 0 only in the cycle after ovf_clr is high, and an overflow event in that same cycle wins, leaving ovf at 1.
- R5: Opcodes 2 (signed) and 3 (unsigned) multiply bits [7:0] of both operands and add the 32-bit product to acc_lo only. acc_hi is unchanged. An event occurs when bit 31 of the old acc_lo equals bit 31 of the product and bit 31 of the new acc_lo differs.
- R6: Opcodes 4 (sign-extended) and 5 (zero-extended) multiply bits [15:0] of both operands into a 64-bit product. They accumulate it into {acc_hi, acc_lo} with carry, as in R2.
- R7: Opcodes 6 (signed) and 7 (unsigned) form two 32-bit lane products, p0 = opa[15:0]*opb[15:0] and p1 = opa[31:16]*opb[31:16], and set acc_lo to acc_lo+p0+p1 modulo 2^32. acc_hi is unchanged. An event occurs when bit 31 of the old acc_lo equals bit 31 of p0 and bit 31 of the new acc_lo differs.
- R8: Opcodes 8 (signed) and 9 (unsigned) write the lane product p0 to aux_q and p1 to res_q. acc_hi, acc_lo and ovf are unchanged.
- R9: When in_valid is low, or the opcode is 10 to 15, acc_hi, acc_lo, aux_q and res_q hold. ovf changes only through ovf_clr.
- R10: Results appear on the outputs at the clock edge that accepts the operation. A new operation may be accepted every cycle, and each one sees the state left by the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation accepted at this edge |
| op | input | 4 | Operation select, codes 0 to 9 as in the requirements |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| acc_hi | output | 32 | High accumulator word |
| acc_lo | output | 32 | Low accumulator word |
| aux_q | output | 32 | Auxiliary product register (low-lane product of a dual multiply) |
| res_q | output | 32 | Result word (high-lane product of a dual multiply) |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Every state element is a port, so a wrong carry, a wrong extension or a mode writing the wrong word shows as a mismatch on acc_hi, acc_lo, aux_q, res_q or ovf in the cycle right after the faulty operation. Because the accumulator is cumulative, a missed carry keeps corrupting every later comparison, so single-cycle slips surface at once. A wrongly set or lost overflow flag stays visible until the next clear, because the flag is sticky. The byte modes are swept near-exhaustively, and the wider modes use operand mixes biased toward sign boundaries so that the carry and overflow paths are exercised.

// File: rtl/mac_pkg.sv
package mac_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_MAC_S  = 4'd0,
    OP_MAC_U  = 4'd1,
    OP_MACB_S = 4'd2,
    OP_MACB_U = 4'd3,
    OP_MACH_S = 4'd4,
    OP_MACH_U = 4'd5,
    OP_DMAC_S = 4'd6,
    OP_DMAC_U = 4'd7,
    OP_DMUL_S = 4'd8,
    OP_DMUL_U = 4'd9
  } mac_op_e;

  typedef enum logic [2:0] {
    K_NONE     = 3'd0,
    K_WIDE     = 3'd1,
    K_LOW      = 3'd2,
    K_DUAL_ACC = 3'd3,
    K_DUAL_MUL = 3'd4
  } mac_kind_e;

  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_HALF = 2'd1,
    SZ_BYTE = 2'd2
  } mac_size_e;

  typedef struct packed {
    mac_kind_e kind;
    mac_size_e size;
    logic      sgn;
  } mac_dec_t;

endpackage

// File: rtl/mac_rst_sync.sv
module mac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mac_op_decode.sv
module mac_op_decode
  import mac_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output mac_dec_t        dec_o
);

  always_comb begin
    dec_o.kind = K_NONE;
    dec_o.size = SZ_WORD;
    dec_o.sgn  = 1'b0;
    case (op_i)
      OP_MAC_S:  begin dec_o.kind = K_WIDE;     dec_o.size = SZ_WORD; dec_o.sgn = 1'b1; end
      OP_MAC_U:  begin dec_o.kind = K_WIDE;     dec_o.size = SZ_WORD; dec_o.sgn = 1'b0; end
      OP_MACB_S: begin dec_o.kind = K_LOW;      dec_o.size = SZ_BYTE; dec_o.sgn = 1'b1; end
      OP_MACB_U: begin dec_o.kind = K_LOW;      dec_o.size = SZ_BYTE; dec_o.sgn = 1'b0; end
      OP_MACH_S: begin dec_o.kind = K_WIDE;     dec_o.size = SZ_HALF; dec_o.sgn = 1'b1; end
      OP_MACH_U: begin dec_o.kind = K_WIDE;     dec_o.size = SZ_HALF; dec_o.sgn = 1'b0; end
      OP_DMAC_S: begin dec_o.kind = K_DUAL_ACC; dec_o.size = SZ_HALF; dec_o.sgn = 1'b1; end
      OP_DMAC_U: begin dec_o.kind = K_DUAL_ACC; dec_o.size = SZ_HALF; dec_o.sgn = 1'b0; end
      OP_DMUL_S: begin dec_o.kind = K_DUAL_MUL; dec_o.size = SZ_HALF; dec_o.sgn = 1'b1; end
      OP_DMUL_U: begin dec_o.kind = K_DUAL_MUL; dec_o.size = SZ_HALF; dec_o.sgn = 1'b0; end
      default:   begin dec_o.kind = K_NONE;     dec_o.size = SZ_WORD; dec_o.sgn = 1'b0; end
    endcase
  end

endmodule

// File: rtl/mac_lane_mul.sv
module mac_lane_mul #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           sgn,
  output logic [2*W-1:0] p
);

  localparam int PW = 2 * W;

  logic [PW-1:0] ext_a;
  logic [PW-1:0] ext_b;

  // Sign or zero extension to the full product width makes the low PW bits
  // of an unsigned multiply equal to the signed or unsigned product.
  assign ext_a = {{W{sgn & a[W-1]}}, a};
  assign ext_b = {{W{sgn & b[W-1]}}, b};
  assign p     = ext_a * ext_b;

endmodule

// File: rtl/mac_acc_adder.sv
module mac_acc_adder
  import mac_pkg::*;
#(
  parameter int W = 32
) (
  input  mac_kind_e      kind,
  input  logic [W-1:0]   hi,
  input  logic [W-1:0]   lo,
  input  logic [2*W-1:0] prod_w,
  input  logic [W-1:0]   lane_p0,
  input  logic [W-1:0]   lane_p1,
  output logic [W-1:0]   hi_nx,
  output logic [W-1:0]   lo_nx,
  output logic           ovf_evt
);

  localparam int MSB = W - 1;

  logic [W:0]   lo_sum;
  logic [W-1:0] hi_sum;
  logic [W-1:0] dual_sum;
  logic         carry;

  assign lo_sum   = {1'b0, lo} + {1'b0, prod_w[W-1:0]};
  assign carry    = lo_sum[W];
  assign hi_sum   = hi + prod_w[2*W-1:W] + {{(W-1){1'b0}}, carry};
  assign dual_sum = lo + lane_p0 + lane_p1;

  always_comb begin
    hi_nx   = hi;
    lo_nx   = lo;
    ovf_evt = 1'b0;
    case (kind)
      K_WIDE: begin
        hi_nx   = hi_sum;
        lo_nx   = lo_sum[W-1:0];
        ovf_evt = (hi[MSB] == prod_w[2*W-1]) && (hi_sum[MSB] != prod_w[2*W-1]);
      end
      K_LOW: begin
        lo_nx   = lo_sum[W-1:0];
        ovf_evt = (lo[MSB] == prod_w[MSB]) && (lo_sum[MSB] != prod_w[MSB]);
      end
      K_DUAL_ACC: begin
        lo_nx   = dual_sum;
        ovf_evt = (lo[MSB] == lane_p0[MSB]) && (dual_sum[MSB] != lane_p0[MSB]);
      end
      default: begin
        hi_nx   = hi;
        lo_nx   = lo;
        ovf_evt = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/mac_split_acc.sv
module mac_split_acc
  import mac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic            ovf_clr,
  output logic [W-1:0]    acc_hi,
  output logic [W-1:0]    acc_lo,
  output logic [W-1:0]    aux_q,
  output logic [W-1:0]    res_q,
  output logic            ovf
);

  localparam int HW    = W / 2;
  localparam int BW    = W / 4;
  localparam int PW    = 2 * W;
  localparam int LANES = 2;

  logic     rst_i_n;
  mac_dec_t dec;

  logic [W-1:0]  wide_a;
  logic [W-1:0]  wide_b;
  logic [PW-1:0] prod_w;
  logic [W-1:0]  lane_p [LANES];

  logic [W-1:0] hi_q, lo_q, aux_r, res_r;
  logic         ovf_q;
  logic [W-1:0] hi_nx, lo_nx, aux_nx, res_nx;
  logic         ovf_nx;
  logic         ovf_evt;
  logic         acc_we, mul_we;

  mac_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  mac_op_decode u_dec (
    .op_i  (op),
    .dec_o (dec)
  );

  // Narrow operand fields are widened so one word multiplier serves all
  // single-product modes.
  always_comb begin
    case (dec.size)
      SZ_BYTE: begin
        wide_a = {{(W-BW){dec.sgn & opa[BW-1]}}, opa[BW-1:0]};
        wide_b = {{(W-BW){dec.sgn & opb[BW-1]}}, opb[BW-1:0]};
      end
      SZ_HALF: begin
        wide_a = {{(W-HW){dec.sgn & opa[HW-1]}}, opa[HW-1:0]};
        wide_b = {{(W-HW){dec.sgn & opb[HW-1]}}, opb[HW-1:0]};
      end
      default: begin
        wide_a = opa;
        wide_b = opb;
      end
    endcase
  end

  mac_lane_mul #(.W(W)) u_wide_mul (
    .a   (wide_a),
    .b   (wide_b),
    .sgn (dec.sgn),
    .p   (prod_w)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    mac_lane_mul #(.W(HW)) u_lane_mul (
      .a   (opa[g*HW +: HW]),
      .b   (opb[g*HW +: HW]),
      .sgn (dec.sgn),
      .p   (lane_p[g])
    );
  end

  mac_acc_adder #(.W(W)) u_add (
    .kind    (dec.kind),
    .hi      (hi_q),
    .lo      (lo_q),
    .prod_w  (prod_w),
    .lane_p0 (lane_p[0]),
    .lane_p1 (lane_p[1]),
    .hi_nx   (hi_nx),
    .lo_nx   (lo_nx),
    .ovf_evt (ovf_evt)
  );

  // Next-state and enables
  always_comb begin
    acc_we = in_valid && ((dec.kind == K_WIDE) || (dec.kind == K_LOW) ||
                          (dec.kind == K_DUAL_ACC));
    mul_we = in_valid && (dec.kind == K_DUAL_MUL);
    aux_nx = lane_p[0];
    res_nx = lane_p[1];
    ovf_nx = (acc_we && ovf_evt) || (ovf_q && !ovf_clr);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      aux_r <= '0;
      res_r <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (acc_we) begin
        hi_q <= hi_nx;
        lo_q <= lo_nx;
      end
      if (mul_we) begin
        aux_r <= aux_nx;
        res_r <= res_nx;
      end
      ovf_q <= ovf_nx;
    end
  end

  assign acc_hi = hi_q;
  assign acc_lo = lo_q;
  assign aux_q  = aux_r;
  assign res_q  = res_r;
  assign ovf    = ovf_q;

endmodule

// File: rtl/mac_split_acc_chk.sv
module mac_split_acc_chk
  import mac_pkg::*;
#(
  parameter int W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [OP_W-1:0] op,
  input logic            ovf_clr,
  input logic [W-1:0]    acc_hi,
  input logic [W-1:0]    acc_lo,
  input logic [W-1:0]    aux_q,
  input logic [W-1:0]    res_q,
  input logic            ovf
);

  logic is_dmul, is_hi_keep, is_idle;
  assign is_dmul    = in_valid && ((op == OP_DMUL_S) || (op == OP_DMUL_U));
  assign is_hi_keep = in_valid && ((op == OP_MACB_S) || (op == OP_MACB_U) ||
                                   (op == OP_DMAC_S) || (op == OP_DMAC_U));
  assign is_idle    = !in_valid || (op > OP_DMUL_U);

  // R4: the flag never drops without a clear
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);

  // R4: a falling flag was caused by a clear
  p_clear_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf && $past(ovf)) |-> $past(ovf_clr));

  // R5 / R7: low-word-only modes keep the high word
  p_hi_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_hi_keep |=> $stable(acc_hi));

  // R8: dual multiply leaves the accumulator and flag alone
  p_dmul_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dmul && !ovf_clr) |=> ($stable(acc_hi) && $stable(acc_lo) && $stable(ovf)));

  // R8: product registers change only on a dual multiply
  p_prod_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !is_dmul |=> ($stable(aux_q) && $stable(res_q)));

  // R9: idle cycles hold every word
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle |=> ($stable(acc_hi) && $stable(acc_lo) && $stable(aux_q) && $stable(res_q)));

  // R9: idle cycles never raise the flag
  p_idle_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_idle && !ovf) |=> !ovf);

endmodule

bind mac_split_acc mac_split_acc_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .op       (op),
  .ovf_clr  (ovf_clr),
  .acc_hi   (acc_hi),
  .acc_lo   (acc_lo),
  .aux_q    (aux_q),
  .res_q    (res_q),
  .ovf      (ovf)
);

// File: tb/tb_mac_split_acc.sv
`timescale 1ns/1ps
module tb_mac_split_acc;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op;
  logic [31:0] opa, opb;
  logic        ovf_clr;
  logic [31:0] acc_hi, acc_lo, aux_q, res_q;
  logic        ovf;

  int n_tests;
  int n_fail;
  bit done;

  logic [31:0] e_hi, e_lo, e_aux, e_res;
  logic        e_ovf;

  mac_split_acc dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .opa(opa), .opb(opb), .ovf_clr(ovf_clr),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .aux_q(aux_q), .res_q(res_q), .ovf(ovf)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic string op_tag(input logic [3:0] o);
    case (o)
      4'd0, 4'd1: return "R2";
      4'd2, 4'd3: return "R5";
      4'd4, 4'd5: return "R6";
      4'd6, 4'd7: return "R7";
      4'd8, 4'd9: return "R8";
      default:    return "R9";
    endcase
  endfunction

  task automatic check(input string tag);
    n_tests++;
    if (acc_hi !== e_hi || acc_lo !== e_lo || aux_q !== e_aux ||
        res_q !== e_res || ovf !== e_ovf) begin
      n_fail++;
      $display("FAIL %s: hi=%h lo=%h aux=%h res=%h ovf=%b expected hi=%h lo=%h aux=%h res=%h ovf=%b",
               tag, acc_hi, acc_lo, aux_q, res_q, ovf, e_hi, e_lo, e_aux, e_res, e_ovf);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; op = '0; opa = '0; opb = '0; ovf_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    e_hi = '0; e_lo = '0; e_aux = '0; e_res = '0; e_ovf = 1'b0;
  endtask

  // Reference model: whole-accumulator arithmetic, not split words
  task automatic model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic v, input logic clr);
    logic [63:0] p, acc;
    logic [31:0] pl, q0, q1, nlo;
    logic        evt;
    evt = 1'b0;
    if (o == 4'd6 || o == 4'd8) begin
      q0 = 32'(int'($signed(a[15:0])) * int'($signed(b[15:0])));
      q1 = 32'(int'($signed(a[31:16])) * int'($signed(b[31:16])));
    end else begin
      q0 = {16'd0, a[15:0]} * {16'd0, b[15:0]};
      q1 = {16'd0, a[31:16]} * {16'd0, b[31:16]};
    end
    if (v) begin
      case (o)
        4'd0, 4'd1, 4'd4, 4'd5: begin
          case (o)
            4'd0:    p = 64'(longint'($signed(a)) * longint'($signed(b)));
            4'd1:    p = {32'd0, a} * {32'd0, b};
            4'd4:    p = 64'(longint'($signed(a[15:0])) * longint'($signed(b[15:0])));
            default: p = {48'd0, a[15:0]} * {48'd0, b[15:0]};
          endcase
          acc  = {e_hi, e_lo} + p;
          evt  = (e_hi[31] == p[63]) && (acc[63] != p[63]);
          e_hi = acc[63:32];
          e_lo = acc[31:0];
        end
        4'd2, 4'd3: begin
          if (o == 4'd2) pl = 32'(int'($signed(a[7:0])) * int'($signed(b[7:0])));
          else           pl = {24'd0, a[7:0]} * {24'd0, b[7:0]};
          nlo  = e_lo + pl;
          evt  = (e_lo[31] == pl[31]) && (nlo[31] != pl[31]);
          e_lo = nlo;
        end
        4'd6, 4'd7: begin
          nlo  = e_lo + q0 + q1;
          evt  = (e_lo[31] == q0[31]) && (nlo[31] != q0[31]);
          e_lo = nlo;
        end
        4'd8, 4'd9: begin
          e_aux = q0;
          e_res = q1;
        end
        default: ;
      endcase
    end
    e_ovf = evt | (e_ovf & ~clr);
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next fall (R10)
  task automatic apply(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic v, input logic clr, input string tag);
    in_valid = v; op = o; opa = a; opb = b; ovf_clr = clr;
    model(o, a, b, v, clr);
    @(negedge clk);
    check(tag);
  endtask

  function automatic logic [31:0] pick_operand();
    case ($urandom % 6)
      0:       return 32'h7FFF_FFFF - ($urandom % 4);
      1:       return 32'h8000_0000 + ($urandom % 4);
      2:       return {$urandom % 2 == 0 ? 16'h7FFF : 16'h8000, 16'($urandom)};
      3:       return {16'($urandom), $urandom % 2 == 0 ? 16'hFFFF : 16'h8000};
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] rops [8];
    n_tests = 0; n_fail = 0; done = 0;
    rops[0] = 4'd0; rops[1] = 4'd1; rops[2] = 4'd4; rops[3] = 4'd5;
    rops[4] = 4'd6; rops[5] = 4'd7; rops[6] = 4'd8; rops[7] = 4'd9;

    // R1: reset state
    do_reset();
    check("R1");

    // R3: signed full accumulate overflows on the third step
    apply(4'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0, "R2");
    check_bit("R3 no event step1", ovf, 1'b0);
    apply(4'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0, "R2");
    apply(4'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0, "R3");
    check_bit("R3 flag set", ovf, 1'b1);
    n_tests++;
    if (acc_hi !== 32'hBFFF_FFFD || acc_lo !== 32'h0000_0003) begin
      n_fail++;
      $display("FAIL R2 carry chain: hi=%h lo=%h expected hi=bffffffd lo=00000003", acc_hi, acc_lo);
    end

    // R4: sticky across operations, cleared by ovf_clr
    apply(4'd1, 32'd3, 32'd5, 1'b1, 1'b0, "R4");
    check_bit("R4 sticky", ovf, 1'b1);
    apply(4'd2, 32'd1, 32'd1, 1'b1, 1'b0, "R4");
    check_bit("R4 sticky byte", ovf, 1'b1);
    apply(4'd0, 32'd0, 32'd0, 1'b0, 1'b1, "R4");
    check_bit("R4 cleared", ovf, 1'b0);

    // R4: event and clear in the same cycle, event wins
    do_reset();
    apply(4'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0, "R2");
    apply(4'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0, "R2");
    apply(4'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b1, "R4");
    check_bit("R4 set beats clear", ovf, 1'b1);

    // R8: dual multiply with known values
    apply(4'd8, 32'hFFFF_0003, 32'h0002_FFFB, 1'b1, 1'b0, "R8");
    n_tests++;
    if (aux_q !== 32'hFFFF_FFF1 || res_q !== 32'hFFFF_FFFE) begin
      n_fail++;
      $display("FAIL R8 lanes: aux=%h res=%h expected aux=fffffff1 res=fffffffe", aux_q, res_q);
    end

    // R9: invalid opcodes and idle cycles
    for (int k = 10; k < 16; k++)
      apply(4'(k), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, "R9");
    for (int k = 0; k < 10; k++)
      apply(4'(k), 32'h8000_0001, 32'h7FFF_FFFF, 1'b0, 1'b0, "R9");

    // R6: halfword with carry out of the low word
    do_reset();
    apply(4'd5, 32'h0000_FFFF, 32'h0000_FFFF, 1'b1, 1'b0, "R6");
    for (int k = 0; k < 4; k++)
      apply(4'd4, 32'h0000_8000, 32'h0000_7FFF, 1'b1, 1'b0, "R6");

    // R5: near-exhaustive byte sweeps
    for (int m = 2; m < 4; m++) begin
      do_reset();
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += 7)
          apply(4'(m), {24'($urandom), 8'(a)}, {24'($urandom), 8'(b)}, 1'b1, 1'b0, "R5");
    end

    // Mixed operations per mode, back-to-back, with sparse idles and clears
    for (int i = 0; i < 8; i++) begin
      do_reset();
      for (int k = 0; k < 1500; k++)
        apply(rops[i], pick_operand(), pick_operand(), ($urandom % 8) != 0,
              ($urandom % 64) == 0, op_tag(rops[i]));
    end

    // R10: fully interleaved modes, every cycle valid
    do_reset();
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] o;
      o = 4'($urandom % 16);
      apply(o, pick_operand(), pick_operand(), 1'b1, ($urandom % 32) == 0, "R10");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule